// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a synchronous burst static memory with a flow-through read path. The word is two 9-bit byte lanes, each holding eight data bits and one parity bit. Every rising clock edge samples three chip enables, two address-load strobes, a burst advance input, the write controls and a snooze input. From these the block decides whether the edge deselects the device, begins a burst at an external address, continues a burst at the next internal address, or suspends a burst at the current address. It also decides whether the edge reads or writes.

The processor-side strobe (`adsp_n_i`) always begins a read, and only when the primary enable is low. The controller-side strobe (`adsc_n_i`) begins a read or a write, and it deselects the device when the primary enable is high. The burst offset steps through four addresses in linear or interleaved order. Read data comes straight from the array, addressed by the registered burst address, so it appears in the same cycle as the edge that started the access, with no output register. The data bus is a driven value plus an enable, and the enable also depends on the asynchronous output enable and on the snooze input.

Top module: `fts_burst_sram`

## Requirements
- R1: When `ce_n_i` is high, a low `adsp_n_i` has no effect. If `adsc_n_i` is also high, an active burst suspends and the bus keeps showing the word at the current address, not the word at `addr_i`.
- R2: With the device selected, a low `adsp_n_i` loads `addr_i` and begins a read even when the write inputs request a write. `q_o` shows that word in the cycle after the edge.
- R3: A low `adsc_n_i` (with `adsp_n_i` high, or with `ce_n_i` high) and a selected device loads `addr_i` and performs a read or a write there. With `ce_n_i` high it deselects the device, and the bus goes high-impedance.
- R4: The device is selected only when `ce_n_i`=0, `ce2_n_i`=0 and `ce2_i`=1. An address load with any other combination deselects. The enables are ignored on edges that do not load an address.
- R5: An edge is a write when `gw_n_i`=0, which writes both lanes, or when `bwe_n_i`=0 and at least one bit of `bw_n_i` is 0. If `gw_n_i` and `bwe_n_i` are both high, the edge is a read whatever `bw_n_i` is.
- R6: `bw_n_i[0]` gates lane a, which is bus bits [7:0] and parity bit 16. `bw_n_i[1]` gates lane b, which is bits [15:8] and parity bit 17. Bits of a lane that is not enabled keep their value.
- R7: `adv_n_i`=0 steps the 2-bit burst offset and `adv_n_i`=1 holds it. With `linear_i`=1 the low two address bits are (base+k) mod 4. With `linear_i`=0 they are base XOR k, where k is the step count.
- R8: After a processor-side load, an edge with a write request and `adv_n_i`=1 writes the loaded address.
- R9: While `zz_i` is high, the bus is high-impedance, strobes and writes are ignored and the memory is kept. The device is left deselected.
- R10: `q_en_o` is low whenever `oe_n_i` is high, and after any write edge or deselect edge.
- R11: After a write, a suspend edge without a write leaves the bus high-impedance. A read that is begun by a strobe, or continued by an advance, drives it again.
- R12: During and right after reset the device is deselected and `q_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | External word address |
| d_i | input | 18 | Write data: [7:0] lane a, [15:8] lane b, 16 parity a, 17 parity b |
| ce_n_i | input | 1 | Primary chip enable, active low |
| ce2_n_i | input | 1 | Secondary chip enable, active low |
| ce2_i | input | 1 | Secondary chip enable, active high |
| adsp_n_i | input | 1 | Processor-side address load strobe, active low |
| adsc_n_i | input | 1 | Controller-side address load strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write master enable, active low |
| bw_n_i | input | 2 | Per-lane write enables, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| zz_i | input | 1 | Snooze, active high |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| q_o | output | 18 | Read data, zero when not driven |
| q_en_o | output | 1 | Output driver enable (tri-state control) |

## Verification
Two functions can fall in the same cycle. The first case is a processor-side load on the same edge as a write request. The second is snooze on the same edge as a controller-side write. The bench drives both at once. It judges the first by the bus showing the old word in the next cycle, and by a follow-up edge with the advance input held high that performs the write. It judges the second by reading the target word back after snooze ends and finding it unchanged.

// File: rtl/fts_sram_pkg.sv
// Package: shared cycle classification for the flow-through burst SRAM.
// Assumes: one classification per rising clock edge.
package fts_sram_pkg;

    typedef enum logic [2:0] {
        CYC_HOLD   = 3'd0,  // deselected and no load: nothing happens
        CYC_DESEL  = 3'd1,  // address load that leaves the device deselected
        CYC_BEGIN  = 3'd2,  // external address loaded, burst begins
        CYC_CONT   = 3'd3,  // burst offset steps to the next address
        CYC_SUSP   = 3'd4,  // burst offset held at the current address
        CYC_SNOOZE = 3'd5   // snooze input high, all else ignored
    } cyc_e;

endpackage

// File: rtl/sram_cmd_decode.sv
// Module: sram_cmd_decode
// Classifies the sampled control inputs into one cycle kind and a per-lane
// write mask. Purely combinational.
// Assumes: active_i is the registered "device selected" state.
module sram_cmd_decode
    import fts_sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             active_i,
    input  logic             ce_n_i,
    input  logic             ce2_n_i,
    input  logic             ce2_i,
    input  logic             adsp_n_i,
    input  logic             adsc_n_i,
    input  logic             adv_n_i,
    input  logic             gw_n_i,
    input  logic             bwe_n_i,
    input  logic [LANES-1:0] bw_n_i,
    input  logic             zz_i,
    output cyc_e             kind_o,
    output logic             wr_o,
    output logic [LANES-1:0] lane_we_o
);

    logic             sel;
    logic [LANES-1:0] lanes;

    // Write lane decode: global write wins, else master enable gates the lanes.
    always_comb begin
        if (!gw_n_i) begin
            lanes = '1;
        end else if (!bwe_n_i) begin
            lanes = ~bw_n_i;
        end else begin
            lanes = '0;
        end
    end

    assign sel       = !ce_n_i && !ce2_n_i && ce2_i;
    assign lane_we_o = lanes;

    // Cycle kind by priority: snooze, processor load, controller load, burst.
    always_comb begin
        kind_o = CYC_HOLD;
        wr_o   = 1'b0;
        if (zz_i) begin
            kind_o = CYC_SNOOZE;
        end else if (!adsp_n_i && !ce_n_i) begin
            kind_o = sel ? CYC_BEGIN : CYC_DESEL;
        end else if (!adsc_n_i) begin
            kind_o = sel ? CYC_BEGIN : CYC_DESEL;
            wr_o   = sel && (|lanes);
        end else if (active_i) begin
            kind_o = adv_n_i ? CYC_SUSP : CYC_CONT;
            wr_o   = |lanes;
        end
    end

endmodule

// File: rtl/sram_burst_seq.sv
// Module: sram_burst_seq
// Holds the loaded base address and a burst step count, and gives the
// current address and the address after this edge's update.
// Assumes: load_i and step_i are never both high.
module sram_burst_seq #(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              linear_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [ADDR_W-1:0] nxt_addr_o
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    hi_q, hi_d;
    logic [BURST_W-1:0] base_q, base_d, cnt_q, cnt_d;

    // Burst ordering: linear adds the step count, interleaved XORs it.
    function automatic logic [BURST_W-1:0] order(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               lin
    );
        return lin ? (base + cnt) : (base ^ cnt);
    endfunction

    // Next-state selection for the address fields.
    always_comb begin
        hi_d   = hi_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        if (load_i) begin
            hi_d   = ext_addr_i[ADDR_W-1:BURST_W];
            base_d = ext_addr_i[BURST_W-1:0];
            cnt_d  = '0;
        end else if (step_i) begin
            cnt_d  = cnt_q + 1'b1;
        end
    end

    // Address field registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            hi_q   <= hi_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    assign cur_addr_o = {hi_q, order(base_q, cnt_q, linear_i)};
    assign nxt_addr_o = {hi_d, order(base_d, cnt_d, linear_i)};

endmodule

// File: rtl/sram_lane_array.sv
// Module: sram_lane_array
// One storage array per byte lane, with a synchronous write and an
// asynchronous read (flow-through).
// Assumes: contents are not reset; each lane has its own write enable.
module sram_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                         clk,
    input  logic [LANES-1:0]             we_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [LANES-1:0][LANE_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0]            rd_addr_i,
    output logic [LANES-1:0][LANE_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        // Lane write port.
        always_ff @(posedge clk) begin
            if (we_i[l]) begin
                mem_q[wr_addr_i] <= wr_data_i[l];
            end
        end

        assign rd_data_o[l] = mem_q[rd_addr_i];
    end

endmodule

// File: rtl/fts_burst_sram.sv
// Module: fts_burst_sram (top)
// Flow-through synchronous burst SRAM with byte lanes plus parity, two address
// load strobes, a burst sequencer and snooze. The output enable and snooze
// gate the driver enable asynchronously.
// Assumes: bus layout is {parity[LANES-1:0], data[LANES*DATA_W-1:0]}.
module fts_burst_sram
    import fts_sram_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 2,
    parameter int DATA_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [LANES*(DATA_W+1)-1:0] d_i,
    input  logic                        ce_n_i,
    input  logic                        ce2_n_i,
    input  logic                        ce2_i,
    input  logic                        adsp_n_i,
    input  logic                        adsc_n_i,
    input  logic                        adv_n_i,
    input  logic                        gw_n_i,
    input  logic                        bwe_n_i,
    input  logic [LANES-1:0]            bw_n_i,
    input  logic                        oe_n_i,
    input  logic                        zz_i,
    input  logic                        linear_i,
    output logic [LANES*(DATA_W+1)-1:0] q_o,
    output logic                        q_en_o
);

    localparam int LANE_W   = DATA_W + 1;
    localparam int BUS_W    = LANES * LANE_W;
    localparam int PAR_BASE = LANES * DATA_W;

    cyc_e                         kind;
    logic                         wr;
    logic [LANES-1:0]             lane_we;
    logic [LANES-1:0]             mem_we;
    logic                         act_q;
    logic                         rd_q;
    logic [ADDR_W-1:0]            cur_addr;
    logic [ADDR_W-1:0]            nxt_addr;
    logic [LANES-1:0][LANE_W-1:0] wr_lane;
    logic [LANES-1:0][LANE_W-1:0] rd_lane;
    logic [BUS_W-1:0]             q_raw;

    sram_cmd_decode #(.LANES(LANES)) u_dec (
        .active_i (act_q),
        .ce_n_i   (ce_n_i),
        .ce2_n_i  (ce2_n_i),
        .ce2_i    (ce2_i),
        .adsp_n_i (adsp_n_i),
        .adsc_n_i (adsc_n_i),
        .adv_n_i  (adv_n_i),
        .gw_n_i   (gw_n_i),
        .bwe_n_i  (bwe_n_i),
        .bw_n_i   (bw_n_i),
        .zz_i     (zz_i),
        .kind_o   (kind),
        .wr_o     (wr),
        .lane_we_o(lane_we)
    );

    sram_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (kind == CYC_BEGIN),
        .step_i    (kind == CYC_CONT),
        .linear_i  (linear_i),
        .ext_addr_i(addr_i),
        .cur_addr_o(cur_addr),
        .nxt_addr_o(nxt_addr)
    );

    // Lane write enables apply only on access cycles that write.
    always_comb begin
        mem_we = '0;
        if (wr && (kind == CYC_BEGIN || kind == CYC_CONT || kind == CYC_SUSP)) begin
            mem_we = lane_we;
        end
    end

    // Map the bus onto lanes and back: data bits per lane, parity bits on top.
    for (genvar l = 0; l < LANES; l++) begin : g_map
        assign wr_lane[l] = {d_i[PAR_BASE + l], d_i[l*DATA_W +: DATA_W]};
        assign q_raw[l*DATA_W +: DATA_W] = rd_lane[l][DATA_W-1:0];
        assign q_raw[PAR_BASE + l]       = rd_lane[l][DATA_W];
    end

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk      (clk),
        .we_i     (mem_we),
        .wr_addr_i(nxt_addr),
        .wr_data_i(wr_lane),
        .rd_addr_i(cur_addr),
        .rd_data_o(rd_lane)
    );

    // Selected state and read-drive flag, updated per cycle kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            case (kind)
                CYC_DESEL, CYC_SNOOZE: begin
                    act_q <= 1'b0;
                    rd_q  <= 1'b0;
                end
                CYC_BEGIN: begin
                    act_q <= 1'b1;
                    rd_q  <= !wr;
                end
                CYC_CONT: rd_q <= !wr;
                CYC_SUSP: if (wr) rd_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign q_en_o = act_q && rd_q && !oe_n_i && !zz_i;
    assign q_o    = q_en_o ? q_raw : '0;

endmodule

// File: rtl/fts_burst_sram_chk.sv
// Module: fts_burst_sram_chk
// Port-level properties of the burst SRAM, attached by bind.
// Assumes: rst_n is low before the first clock edge.
module fts_burst_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n_i,
    input logic ce2_n_i,
    input logic ce2_i,
    input logic adsp_n_i,
    input logic adsc_n_i,
    input logic gw_n_i,
    input logic oe_n_i,
    input logic zz_i,
    input logic q_en_o
);

    AST_ADSP_BEGINS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n_i && !ce_n_i && !ce2_n_i && ce2_i && !gw_n_i && !zz_i && !oe_n_i)
        |=> (oe_n_i || zz_i || q_en_o)); // R2

    AST_ADSC_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsc_n_i && ce_n_i) |=> !q_en_o); // R3

    AST_ENABLE_GATING: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n_i && !ce_n_i && (ce2_n_i || !ce2_i)) |=> !q_en_o); // R4

    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n_i && !adsc_n_i && !gw_n_i) |=> !q_en_o); // R10

    AST_SNOOZE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        zz_i |=> !q_en_o); // R9

endmodule

bind fts_burst_sram fts_burst_sram_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n_i  (ce_n_i),
    .ce2_n_i (ce2_n_i),
    .ce2_i   (ce2_i),
    .adsp_n_i(adsp_n_i),
    .adsc_n_i(adsc_n_i),
    .gw_n_i  (gw_n_i),
    .oe_n_i  (oe_n_i),
    .zz_i    (zz_i),
    .q_en_o  (q_en_o)
);

// File: tb/fts_burst_sram_test.sv
`timescale 1ns/1ps
// Scoreboard bench: tick() applies one cycle of stimulus, updates a reference
// model and queues the expected bus; the monitor compares after each edge.
module fts_burst_sram_test;

    typedef struct {
        bit          en;
        logic [17:0] q;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  s_addr = '0;
    logic [17:0] s_d = '0;
    logic        s_ce_n = 1'b0, s_ce2_n = 1'b0, s_ce2 = 1'b1;
    logic        s_adsp_n = 1'b1, s_adsc_n = 1'b1, s_adv_n = 1'b1;
    logic        s_gw_n = 1'b1, s_bwe_n = 1'b1;
    logic [1:0]  s_bw_n = 2'b11;
    logic        s_oe_n = 1'b0, s_zz = 1'b0, s_lin = 1'b1;
    logic [17:0] q_o;
    logic        q_en_o;

    int   checks = 0;
    int   fails  = 0;
    exp_t sb[$];
    exp_t mon_e;

    logic [17:0] ref_mem [256];
    bit          r_act = 0, r_rd = 0;
    logic [7:0]  r_start = '0;
    logic [1:0]  r_k = '0;

    always #2.5 clk = ~clk;

    fts_burst_sram uut (
        .clk(clk), .rst_n(rst_n), .addr_i(s_addr), .d_i(s_d),
        .ce_n_i(s_ce_n), .ce2_n_i(s_ce2_n), .ce2_i(s_ce2),
        .adsp_n_i(s_adsp_n), .adsc_n_i(s_adsc_n), .adv_n_i(s_adv_n),
        .gw_n_i(s_gw_n), .bwe_n_i(s_bwe_n), .bw_n_i(s_bw_n),
        .oe_n_i(s_oe_n), .zz_i(s_zz), .linear_i(s_lin),
        .q_o(q_o), .q_en_o(q_en_o)
    );

    function automatic logic [7:0] ref_addr();
        logic [1:0] lo;
        lo = s_lin ? (r_start[1:0] + r_k) : (r_start[1:0] ^ r_k);
        return {r_start[7:2], lo};
    endfunction

    // One clock of stimulus: reference update, expectation, edge, defaults.
    task automatic tick(input string tag);
        logic [17:0] m;
        bit          wr, sel, acc;
        exp_t        e;
        m = '0;
        if (!s_gw_n) m = 18'h3FFFF;
        else if (!s_bwe_n) begin
            if (!s_bw_n[0]) m |= 18'h100FF;
            if (!s_bw_n[1]) m |= 18'h2FF00;
        end
        wr  = (m != 0);
        sel = !s_ce_n && !s_ce2_n && s_ce2;
        acc = 0;
        if (s_zz) begin
            r_act = 0; r_rd = 0;
        end else if (!s_adsp_n && !s_ce_n) begin
            if (sel) begin r_act = 1; r_rd = 1; r_start = s_addr; r_k = 0; end
            else begin r_act = 0; r_rd = 0; end
        end else if (!s_adsc_n) begin
            if (sel) begin r_act = 1; r_start = s_addr; r_k = 0; r_rd = !wr; acc = wr; end
            else begin r_act = 0; r_rd = 0; end
        end else if (r_act) begin
            if (!s_adv_n) begin r_k = r_k + 2'd1; r_rd = !wr; end
            else if (wr) r_rd = 0;
            acc = wr;
        end
        if (acc) ref_mem[ref_addr()] = (ref_mem[ref_addr()] & ~m) | (s_d & m);
        e.en  = r_act && r_rd && !s_oe_n && !s_zz;
        e.q   = e.en ? ref_mem[ref_addr()] : 18'h0;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        s_adsp_n = 1'b1; s_adsc_n = 1'b1; s_adv_n = 1'b1;
        s_gw_n = 1'b1; s_bwe_n = 1'b1; s_bw_n = 2'b11;
    endtask

    // Monitor: compare the bus against the queued expectation after each edge.
    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            mon_e = sb.pop_front();
            checks++;
            if (q_en_o !== mon_e.en || (mon_e.en && q_o !== mon_e.q)) begin
                fails++;
                $display("FAIL %s: actual en=%0b q=%05h expected en=%0b q=%05h",
                         mon_e.tag, q_en_o, q_o, mon_e.en, mon_e.q);
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected done");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (q_en_o !== 1'b0) begin
            fails++;
            $display("FAIL R12 in reset: actual en=%0b expected en=0", q_en_o);
        end
        rst_n = 1'b1;
        tick("R12 idle after reset");

        // R3 / R5 controller-side write then read
        s_adsc_n = 0; s_addr = 8'h10; s_gw_n = 0; s_d = 18'h3A5A5; tick("R3 ADSC write");
        s_adsc_n = 0; s_addr = 8'h10; tick("R3 ADSC read");
        // R6 lane writes
        s_adsc_n = 0; s_bwe_n = 0; s_bw_n = 2'b10; s_d = 18'h00011; tick("R6 lane a write");
        s_adsc_n = 0; tick("R6 lane a readback");
        s_adsc_n = 0; s_bwe_n = 0; s_bw_n = 2'b01; s_d = 18'h2C300; tick("R6 lane b write");
        s_adsc_n = 0; tick("R6 lane b readback");
        // R5 lanes low but master enable high: read
        s_adsc_n = 0; s_bw_n = 2'b00; s_d = 18'h0; tick("R5 lanes without master reads");
        s_adsc_n = 0; tick("R5 contents unchanged");

        // R7 burst write at 0x40, then ordered reads from 0x41
        s_adsc_n = 0; s_addr = 8'h40; s_gw_n = 0; s_d = 18'h10001; tick("R7 burst write 0");
        for (int k = 1; k < 4; k++) begin
            s_adv_n = 0; s_gw_n = 0; s_d = 18'h10001 + 18'h01111 * k; tick("R7 burst write continue");
        end
        s_adsp_n = 0; s_addr = 8'h41; tick("R2 ADSP read");
        for (int k = 1; k < 4; k++) begin
            s_adv_n = 0; tick("R7 linear order");
        end
        s_lin = 0;
        s_adsp_n = 0; s_addr = 8'h41; tick("R2 ADSP read interleaved");
        for (int k = 1; k < 4; k++) begin
            s_adv_n = 0; tick("R7 interleaved order");
        end
        tick("R7 suspend holds");
        s_lin = 1;

        // R1 processor strobe ignored with primary enable high
        s_ce_n = 1; s_adsp_n = 0; s_addr = 8'h10; tick("R1 ADSP ignored");
        s_ce_n = 0;

        // R2 / R8 processor load with write inputs, then write next edge
        s_adsc_n = 0; s_addr = 8'h50; s_gw_n = 0; s_d = 18'h0ABCD; tick("R3 ADSC write 0x50");
        s_adsp_n = 0; s_addr = 8'h50; s_gw_n = 0; s_d = 18'h3FFFF; tick("R2 ADSP with write inputs reads");
        s_gw_n = 0; s_d = 18'h12345; tick("R8 write after ADSP");
        s_adsc_n = 0; s_addr = 8'h50; tick("R8 readback");

        // R11 write then suspend stays high-impedance; advance read drives
        s_adsc_n = 0; s_addr = 8'h40; s_gw_n = 0; s_d = 18'h2AAAA; tick("R11 write 0x40");
        tick("R11 suspend after write stays Z");
        s_adv_n = 0; tick("R11 advance restarts read");

        // R10 output enable
        s_adsc_n = 0; s_addr = 8'h40; s_oe_n = 1; tick("R10 oe high");
        s_oe_n = 0; tick("R10 oe low");

        // R4 enable gating
        s_adsc_n = 0; s_ce2_n = 1; tick("R4 ce2_n high deselects");
        s_ce2_n = 0;
        s_adsp_n = 0; s_ce2 = 0; tick("R4 ce2 low deselects");
        s_ce2 = 1;
        s_adsc_n = 0; s_addr = 8'h40; tick("R4 reselect read");
        s_ce2_n = 1; s_adv_n = 0; tick("R4 enables ignored mid-burst");
        s_ce2_n = 0;
        s_adsc_n = 0; s_ce_n = 1; tick("R3 ADSC deselect");
        s_ce_n = 0;

        // R9 snooze with a coinciding write
        s_adsc_n = 0; s_addr = 8'h10; tick("R9 read before snooze");
        s_zz = 1; s_adsc_n = 0; s_gw_n = 0; s_d = 18'h00000; tick("R9 snooze write ignored");
        tick("R9 snooze idle");
        s_zz = 0; tick("R9 deselected after snooze");
        s_adsc_n = 0; s_addr = 8'h10; tick("R9 contents kept");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        summary();
    end

endmodule